// File: doc/BRIEF.md
# Sleep Entry Power-Down Sequencer

This block takes a small microcontroller subsystem from run mode into a hardware sleep state. Firmware starts the sequence by writing a control register with its sleep bit set. The block raises a halt request to the CPU at once, without waiting for a clock edge. It then waits for the CPU to acknowledge at an instruction boundary. One half cycle after the rising clock edge that samples the acknowledge, on the falling CPU clock edge, it asserts a system-wide power-down level.

While power-down is high, the block turns off the enables of three domains: flash, the main system oscillator and the bandgap reference. The low-speed oscillator, the reference refresh logic and the supply monitor keep their enables on. A wake event is sampled on the low-speed clock and carried into the CPU clock domain. It clears the sleep bit, the halt request and power-down, and returns the block to idle.

Top module: `pwrdn_seq`

## Requirements
- R1: A write (`wr_en` high) whose data has bit 3 (`SLEEP_BIT`) set, made while idle, raises `bus_req` combinationally in the same cycle, before the next rising `clk` edge.
- R2: Once requested, `bus_req` stays high and `pwr_down` stays low until `bus_ack` is sampled high on a rising `clk` edge, however many cycles that takes.
- R3: `pwr_down` rises on the falling `clk` edge that directly follows the rising edge at which `bus_ack` is first sampled high. With an acknowledge launched 0.5 ns after a rising edge, this is 7.0 ns after the acknowledge rises at a 5 ns period.
- R4: A started sequence always completes. Writes made after the sleep request, including writes with bit 3 clear, change neither `bus_req` nor `pwr_down`.
- R5: `dom_en` bits 0 (flash), 1 (main oscillator) and 2 (bandgap reference) are 0 while `pwr_down` is high and 1 otherwise.
- R6: `dom_en` bits 3 (low-speed oscillator), 4 (reference refresh) and 5 (supply monitor) stay 1 at all times, including during sleep.
- R7: `wake_evt` is captured on rising `lf_clk` edges and then passes through two `clk` flops. In sleep, the first rising `clk` edge that sees it clears the sleep bit and `bus_req`. `pwr_down` falls on the next falling edge.
- R8: While `rst_n` is low, `bus_req` and `pwr_down` are 0 and all `dom_en` bits are 1. The internal reset is released on the second rising `clk` edge after `rst_n` goes high.
- R9: A write while idle with bit 3 clear, whatever the other data bits hold, leaves `bus_req` and `pwr_down` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| lf_clk | input | 1 | Low-speed clock used to sample the wake event |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data, bit 3 is the sleep bit |
| bus_ack | input | 1 | CPU acknowledge of the halt request |
| wake_evt | input | 1 | Wake event level |
| bus_req | output | 1 | Halt request to the CPU |
| pwr_down | output | 1 | System-wide power-down, changes on falling `clk` |
| dom_en | output | 6 | Domain enables: flash, main osc, vref, low-speed osc, refresh, supply monitor |

## Verification
The bench goes after the edge placement of power-down. A design that asserts it on the rising edge, or one cycle late, misses the fixed 7.0 ns gap from acknowledge to power-down. It delays the acknowledge for several cycles and writes zero in the meantime. A block that times out, or that lets the write cancel the request, drops the request or raises power-down early. It also drives writes without the sleep bit while idle, checks that the three always-on enables never fall, and checks the exact edge at which wake clears the request and power-down. A flop too many or too few in the wake path shifts that edge and is reported.

// File: rtl/pwrdn_seq_pkg.sv
`timescale 1ns/1ps
package pwrdn_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_REQ      = 2'd1,
    ST_WAIT_NEG = 2'd2,
    ST_SLEEP    = 2'd3
  } seq_state_e;
endpackage

// File: rtl/pwrdn_rst_sync.sv
`timescale 1ns/1ps
module pwrdn_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pwrdn_wake_sync.sv
`timescale 1ns/1ps
module pwrdn_wake_sync #(
  parameter int STAGES = 2
) (
  input  logic lf_clk,
  input  logic lf_rst_n,
  input  logic clk,
  input  logic rst_n,
  input  logic wake_evt,
  output logic wake_s
);
  logic              lf_cap_q;
  logic [STAGES-1:0] sync_q;

  // capture in the low-speed domain
  always_ff @(posedge lf_clk or negedge lf_rst_n) begin
    if (!lf_rst_n) lf_cap_q <= 1'b0;
    else           lf_cap_q <= wake_evt;
  end

  // carry into the CPU clock domain
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], lf_cap_q};
  end

  assign wake_s = sync_q[STAGES-1];
endmodule

// File: rtl/pwrdn_fsm.sv
`timescale 1ns/1ps
module pwrdn_fsm
  import pwrdn_seq_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int SLEEP_BIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              bus_ack,
  input  logic              wake_s,
  output logic              bus_req,
  output logic              pd_arm
);
  localparam logic [DATA_W-1:0] SLEEP_MASK = DATA_W'(1) << SLEEP_BIT;

  seq_state_e state_q, state_d;
  logic       sleep_q, sleep_d;
  logic       wr_hit;

  assign wr_hit = wr_en && ((wr_data & SLEEP_MASK) != '0);

  always_comb begin
    state_d = state_q;
    sleep_d = sleep_q;
    case (state_q)
      ST_IDLE:     if (wr_hit) begin state_d = ST_REQ; sleep_d = 1'b1; end
      ST_REQ:      if (bus_ack) state_d = ST_WAIT_NEG;
      ST_WAIT_NEG: state_d = ST_SLEEP;
      ST_SLEEP:    if (wake_s) begin state_d = ST_IDLE; sleep_d = 1'b0; end
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sleep_q <= 1'b0;
    end else begin
      state_q <= state_d;
      sleep_q <= sleep_d;
    end
  end

  // request rises straight from the write, then holds from the register
  assign bus_req = rst_n && (sleep_q || (state_q == ST_IDLE && wr_hit));
  assign pd_arm  = (state_q == ST_WAIT_NEG) || (state_q == ST_SLEEP);

  a_r2_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_REQ && !bus_ack) |=> (state_q == ST_REQ && sleep_q));

  a_r4_sleep_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_q && !(state_q == ST_SLEEP && wake_s)) |=> sleep_q);

  a_r7_wake_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLEEP && wake_s) |=> (!sleep_q && state_q == ST_IDLE));
endmodule

// File: rtl/pwrdn_neg_align.sv
`timescale 1ns/1ps
module pwrdn_neg_align (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_arm,
  output logic pd
);
  logic pd_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) pd_q <= 1'b0;
    else        pd_q <= pd_arm;
  end

  assign pd = pd_q;

  a_r4_pd_holds: assert property (@(negedge clk) disable iff (!rst_n)
    (pd_q && pd_arm) |=> pd_q);
endmodule

// File: rtl/pwrdn_domain_gate.sv
`timescale 1ns/1ps
module pwrdn_domain_gate #(
  parameter int                 NUM_DOM    = 6,
  parameter logic [NUM_DOM-1:0] GATED_MASK = 6'b000111
) (
  input  logic               pd,
  output logic [NUM_DOM-1:0] dom_en
);
  for (genvar i = 0; i < NUM_DOM; i++) begin : g_dom
    if (GATED_MASK[i]) begin : g_gated
      assign dom_en[i] = ~pd;
    end else begin : g_alive
      assign dom_en[i] = 1'b1;
    end
  end
endmodule

// File: rtl/pwrdn_seq.sv
`timescale 1ns/1ps
module pwrdn_seq #(
  parameter int                 DATA_W      = 8,
  parameter int                 SLEEP_BIT   = 3,
  parameter int                 NUM_DOM     = 6,
  parameter logic [NUM_DOM-1:0] GATED_MASK  = 6'b000111,
  parameter int                 SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               lf_clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               bus_ack,
  input  logic               wake_evt,
  output logic               bus_req,
  output logic               pwr_down,
  output logic [NUM_DOM-1:0] dom_en
);
  logic rst_core_n, rst_lf_n, wake_s, pd_arm;

  pwrdn_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_core (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_core_n));

  pwrdn_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_lf (
    .clk(lf_clk), .rst_n(rst_n), .rst_sync_n(rst_lf_n));

  pwrdn_wake_sync #(.STAGES(SYNC_STAGES)) u_wake (
    .lf_clk(lf_clk), .lf_rst_n(rst_lf_n), .clk(clk), .rst_n(rst_core_n),
    .wake_evt(wake_evt), .wake_s(wake_s));

  pwrdn_fsm #(.DATA_W(DATA_W), .SLEEP_BIT(SLEEP_BIT)) u_fsm (
    .clk(clk), .rst_n(rst_core_n), .wr_en(wr_en), .wr_data(wr_data),
    .bus_ack(bus_ack), .wake_s(wake_s), .bus_req(bus_req), .pd_arm(pd_arm));

  pwrdn_neg_align u_neg (
    .clk(clk), .rst_n(rst_core_n), .pd_arm(pd_arm), .pd(pwr_down));

  pwrdn_domain_gate #(.NUM_DOM(NUM_DOM), .GATED_MASK(GATED_MASK)) u_gate (
    .pd(pwr_down), .dom_en(dom_en));

  a_r3_pd_after_ack: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(pwr_down) |-> $past(bus_ack));

  a_r4_pd_with_req: assert property (@(posedge clk) disable iff (!rst_core_n)
    pwr_down |-> bus_req);
endmodule

// File: tb/pwrdn_seq_tb.sv
`timescale 1ns/100ps
module pwrdn_seq_tb;
  logic       clk = 1'b0, lf_clk = 1'b0, rst_n = 1'b0;
  logic       wr_en = 1'b0, bus_ack = 1'b0, wake_evt = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       bus_req, pwr_down;
  logic [5:0] dom_en;

  int  n_chk = 0, n_fail = 0;
  bit  done = 0, ack_hold = 0, req_late = 0;
  real t_ack = 0.0;

  // reference model state
  bit m_r1 = 0, m_r2 = 0, m_s1 = 0, m_s2 = 0, m_wlf = 0, m_sleep = 0, m_pd = 0;
  int m_state = 0;

  pwrdn_seq u_dut (.clk(clk), .lf_clk(lf_clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_data(wr_data), .bus_ack(bus_ack), .wake_evt(wake_evt),
    .bus_req(bus_req), .pwr_down(pwr_down), .dom_en(dom_en));

  initial forever #2.5 clk = ~clk;               // 200 MHz
  initial begin #1.25; forever #20 lf_clk = ~lf_clk; end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  // CPU model: acknowledges one rising edge after it sees the request
  always @(negedge clk) begin #1.5; req_late = bus_req; end
  always @(posedge clk) begin #0.5; bus_ack = req_late && !ack_hold; end

  always @(posedge lf_clk) m_wlf = wake_evt;

  always @(posedge clk) begin
    bit old_r, wk, hit;
    old_r = m_r2;
    if (!rst_n) begin m_r1 = 0; m_r2 = 0; end
    else begin m_r2 = m_r1; m_r1 = 1; end
    wk = m_s2;
    if (!old_r) begin
      m_s1 = 0; m_s2 = 0; m_state = 0; m_sleep = 0;
    end else begin
      m_s2 = m_s1; m_s1 = m_wlf;
      hit = wr_en && wr_data[3];
      case (m_state)
        0: if (hit) begin m_state = 1; m_sleep = 1; end
        1: if (bus_ack) m_state = 2;
        2: m_state = 3;
        3: if (wk) begin m_state = 0; m_sleep = 0; end
        default: m_state = 0;
      endcase
    end
    #1.0;
    begin
      bit exp_req;
      exp_req = m_r2 && (m_sleep || (m_state == 0 && wr_en && wr_data[3]));
      chk(bus_req == exp_req, "R1 bus_req vs model", bus_req, exp_req);
      chk(pwr_down == m_pd, "R3 pwr_down vs model", pwr_down, m_pd);
      chk(dom_en[2:0] == {3{~m_pd}}, "R5 gated enables", dom_en[2:0], {3{~m_pd}});
      chk(dom_en[5:3] == 3'b111, "R6 live enables", dom_en[5:3], 7);
    end
  end

  always @(negedge clk) begin
    m_pd = m_r2 && (m_state >= 2);
    #1.0;
    chk(pwr_down == m_pd, "R3 pwr_down at falling edge", pwr_down, m_pd);
  end

  always @(posedge bus_ack) t_ack = $realtime;
  always @(posedge pwr_down) begin
    int gap;
    gap = $rtoi(($realtime - t_ack) * 10.0 + 0.5);
    chk(gap == 70, "R3 ack-to-power-down gap x0.1ns", gap, 70);
  end

  task automatic cyc();
    @(posedge clk); #0.5;
  endtask

  task automatic wr(input logic [7:0] d);
    cyc();
    wr_en = 1'b1; wr_data = d;
    #0.3;
    if (d[3] && m_state == 0)
      chk(bus_req == 1'b1, "R1 request before edge", bus_req, 1);
    cyc();
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic do_wake();
    wake_evt = 1'b1;
    for (int i = 0; i < 12; i++) cyc();
    wake_evt = 1'b0;
    for (int i = 0; i < 12; i++) cyc();
    chk(bus_req == 1'b0, "R7 request cleared by wake", bus_req, 0);
    chk(pwr_down == 1'b0, "R7 power-down cleared by wake", pwr_down, 0);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) cyc();
    chk(bus_req == 1'b0, "R8 reset bus_req", bus_req, 0);
    chk(pwr_down == 1'b0, "R8 reset pwr_down", pwr_down, 0);
    chk(dom_en == 6'h3F, "R8 reset enables", dom_en, 6'h3F);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) cyc();

    // R9: writes without the sleep bit
    wr(8'h00); wr(8'hF7); wr(8'h04);
    chk(bus_req == 1'b0 && pwr_down == 1'b0, "R9 no request", {bus_req, pwr_down}, 0);

    // basic entry
    wr(8'h08);
    for (int i = 0; i < 5; i++) cyc();
    chk(pwr_down == 1'b1, "R3 asleep", pwr_down, 1);
    chk(dom_en == 6'h38, "R5 R6 sleep enables", dom_en, 6'h38);
    do_wake();

    // R2/R4: acknowledge withheld, zero written meanwhile
    ack_hold = 1;
    wr(8'hFF);
    wr(8'h00);
    for (int i = 0; i < 4; i++) cyc();
    chk(bus_req == 1'b1, "R2 request held", bus_req, 1);
    chk(pwr_down == 1'b0, "R2 no power-down before ack", pwr_down, 0);
    ack_hold = 0;
    for (int i = 0; i < 5; i++) cyc();
    chk(pwr_down == 1'b1, "R4 sequence completed", pwr_down, 1);
    wr(8'h00);
    chk(pwr_down == 1'b1 && bus_req == 1'b1, "R4 write ignored in sleep",
        {bus_req, pwr_down}, 3);
    do_wake();

    // re-entry after wake
    wr(8'h08);
    for (int i = 0; i < 5; i++) cyc();
    chk(pwr_down == 1'b1, "R7 re-entry after wake", pwr_down, 1);
    do_wake();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule